// File: doc/BRIEF.md
# PHY Management Register Responder

This block answers management-interface accesses as if it were the register file of an external Ethernet PHY. Software writes a 32-bit command word that names a PHY address, a register number and a direction. The block carries out the command on the clock edge that accepts it. A read loads the selected PHY register into the data register. A write takes its value from the data register.

Inside, the block keeps a control register and an advertisement register. It builds a status register whose link bit tracks an external link-up input. The identifier and link-partner registers return fixed values. A self-clearing reset bit in the control register reloads the control defaults and leaves advertisement and link state alone. Commands addressed to any PHY address other than the configured one are dropped. The command word is still stored.

Top module: `phy_mgmt_resp`

## Requirements
- R1: After reset the command register reads 0, the data register reads 0, control is 0x3100, advertisement is 0x0000 and status is 0xFE28 while the link input is low.
- R2: A command write is stored in the command register with bit 0 (busy) forced to zero. It reads back on cmd_rdata from the cycle after the write.
- R3: A command whose address field (bits 15:12) differs from parameter PHY_ADDR changes neither the data register nor any PHY register.
- R4: A read command (bit 1 clear) to register number bits 7:4 = 1 returns 0xFE28 with bit 2 equal to the registered link state, zero-extended, in data_rdata from the next cycle.
- R5: A write command (bit 1 set) to register 0 without data bit 15 stores data[15:0] with bits 15 and 9 cleared.
- R6: A write to register 0 with data bit 15 set loads control with 0x3100 whatever the other data bits are. It leaves advertisement and the link bit unchanged.
- R7: Register 2 reads 0x0044 and register 3 reads 0x1400. Writes to either one change nothing.
- R8: Register 4 stores data[15:0] on write and returns it on read.
- R9: Register 5 reads the constant 0x0DE0.
- R10: Register numbers 6 to 15 read as zero. Writes to them alter no other register.
- R11: Status bit 2 follows link_up_i one clock later, with no command needed.
- R12: A read command that matches the address takes priority over a data_we in the same cycle. A write command uses the data register value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up_i | input | 1 | External link-up indication |
| cmd_we | input | 1 | Command register write strobe; the command executes on this edge |
| cmd_wdata | input | DATA_W | Command word: address 15:12, register 7:4, write flag bit 1 |
| cmd_rdata | output | DATA_W | Stored command word, busy bit always zero |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | DATA_W | Value for the data register |
| data_rdata | output | DATA_W | Data register: write source and read result |

## Verification
The bench drives commands at the matching address and at a foreign address. A foreign command that leaves data and advertisement unchanged separates correct address decoding from a decoder that ignores the address. Control writes are tried with bit 15 clear and set, using values that carry bit 9 and the other bits. These show masking apart from reload, and show reload apart from plain storage. Reads of the fixed registers, the writable register and unused register numbers, made after writes of marker values, separate a correct read mux from aliased decoding. Toggling the link input with no command issued confirms that status follows the input without waiting for a command.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int REG_W  = 16;
    localparam int RNUM_W = 4;
    localparam int ADDR_W = 4;

    // Command word field positions
    localparam int CMD_ADDR_LSB = 12;
    localparam int CMD_RNUM_LSB = 4;
    localparam int CMD_WR_BIT   = 1;

    typedef enum logic [RNUM_W-1:0] {
        PREG_CTRL    = 4'd0,
        PREG_STATUS  = 4'd1,
        PREG_ID_HI   = 4'd2,
        PREG_ID_LO   = 4'd3,
        PREG_ADV     = 4'd4,
        PREG_PARTNER = 4'd5
    } preg_e;

    typedef struct packed {
        logic              valid;  // command accepted for this PHY
        logic              wr;     // 1 = write, 0 = read
        logic [RNUM_W-1:0] rnum;
    } pcmd_t;

    localparam logic [REG_W-1:0] CTRL_DEFAULT  = 16'h3100;
    localparam logic [REG_W-1:0] CTRL_WR_CLEAR = 16'h8200;
    localparam int               CTRL_RST_BIT  = 15;
    localparam logic [REG_W-1:0] STATUS_BASE   = 16'hFE28;
    localparam int               STATUS_LINK   = 2;
    localparam logic [REG_W-1:0] ID_HI_VALUE   = 16'h0044;
    localparam logic [REG_W-1:0] ID_LO_VALUE   = 16'h1400;
    localparam logic [REG_W-1:0] PARTNER_VALUE = 16'h0DE0;

    function automatic logic [REG_W-1:0] status_word(input logic link);
        logic [REG_W-1:0] s;
        s = STATUS_BASE;
        s[STATUS_LINK] = link;
        return s;
    endfunction

endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
    import phy_mgmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic              cmd_we,
    input  logic [DATA_W-1:0] cmd_word,
    output pcmd_t             cmd
);
    logic [ADDR_W-1:0] addr_f;

    always_comb begin
        addr_f    = cmd_word[CMD_ADDR_LSB +: ADDR_W];
        cmd.valid = cmd_we && (addr_f == PHY_ADDR);
        cmd.wr    = cmd_word[CMD_WR_BIT];
        cmd.rnum  = cmd_word[CMD_RNUM_LSB +: RNUM_W];
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             link_up_i,
    input  pcmd_t            cmd,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] adv_q;
    logic             link_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_DEFAULT;
            adv_q  <= '0;
            link_q <= 1'b0;
        end else begin
            link_q <= link_up_i;
            if (cmd.valid && cmd.wr) begin
                case (cmd.rnum)
                    PREG_CTRL: begin
                        if (wdata[CTRL_RST_BIT])
                            ctrl_q <= CTRL_DEFAULT;
                        else
                            ctrl_q <= wdata & ~CTRL_WR_CLEAR;
                    end
                    PREG_ADV: adv_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (cmd.rnum)
            PREG_CTRL:    rdata = ctrl_q;
            PREG_STATUS:  rdata = status_word(link_q);
            PREG_ID_HI:   rdata = ID_HI_VALUE;
            PREG_ID_LO:   rdata = ID_LO_VALUE;
            PREG_ADV:     rdata = adv_q;
            PREG_PARTNER: rdata = PARTNER_VALUE;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/phy_mgmt_resp.sv
module phy_mgmt_resp
    import phy_mgmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up_i,
    input  logic              cmd_we,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] cmd_rdata,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_rdata
);
    localparam int PAD_W = DATA_W - REG_W;

    pcmd_t             cmd;
    logic [REG_W-1:0]  reg_rdata;
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] data_q;

    phy_mgmt_decode #(.DATA_W(DATA_W), .PHY_ADDR(PHY_ADDR)) u_dec (
        .cmd_we   (cmd_we),
        .cmd_word (cmd_wdata),
        .cmd      (cmd)
    );

    phy_mgmt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .link_up_i (link_up_i),
        .cmd       (cmd),
        .wdata     (data_q[REG_W-1:0]),
        .rdata     (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (cmd_we)
                cmd_q <= {cmd_wdata[DATA_W-1:1], 1'b0};
            if (cmd.valid && !cmd.wr)
                data_q <= {{PAD_W{1'b0}}, reg_rdata};
            else if (data_we)
                data_q <= data_wdata;
        end
    end

    assign cmd_rdata  = cmd_q;
    assign data_rdata = data_q;
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
    parameter int DATA_W = 32,
    parameter logic [3:0] PHY_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              link_up_i,
    input logic              cmd_we,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic [DATA_W-1:0] cmd_rdata,
    input logic              data_we,
    input logic [DATA_W-1:0] data_rdata
);
    logic own_rd;
    assign own_rd = cmd_we && (cmd_wdata[15:12] == PHY_ADDR) && !cmd_wdata[1];

    a_r2_cmd_stored: assert property (@(posedge clk) disable iff (rst)
        cmd_we |=> (cmd_rdata[DATA_W-1:1] == $past(cmd_wdata[DATA_W-1:1])) && !cmd_rdata[0]);

    a_r3_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_wdata[15:12] != PHY_ADDR && !data_we) |=> $stable(data_rdata));

    a_r4_status_link: assert property (@(posedge clk) disable iff (rst)
        (own_rd && cmd_wdata[7:4] == 4'd1 && $stable(link_up_i) && !$past(rst))
        |=> data_rdata == DATA_W'({16'hFE28 | {13'b0, $past(link_up_i), 2'b0}}));

    a_r7_id_high: assert property (@(posedge clk) disable iff (rst)
        (own_rd && cmd_wdata[7:4] == 4'd2) |=> data_rdata == DATA_W'(16'h0044));

    a_r9_partner: assert property (@(posedge clk) disable iff (rst)
        (own_rd && cmd_wdata[7:4] == 4'd5) |=> data_rdata == DATA_W'(16'h0DE0));

    a_r10_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (own_rd && cmd_wdata[7:4] > 4'd5) |=> data_rdata == '0);
endmodule

bind phy_mgmt_resp phy_mgmt_chk #(.DATA_W(DATA_W), .PHY_ADDR(PHY_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_up_i  (link_up_i),
    .cmd_we     (cmd_we),
    .cmd_wdata  (cmd_wdata),
    .cmd_rdata  (cmd_rdata),
    .data_we    (data_we),
    .data_rdata (data_rdata)
);

// File: tb/phy_mgmt_resp_tb.sv
`timescale 1ns/1ps
module phy_mgmt_resp_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          link_up_i = 1'b0;
    logic          cmd_we = 1'b0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [DW-1:0] cmd_rdata;
    logic          data_we = 1'b0;
    logic [DW-1:0] data_wdata = '0;
    logic [DW-1:0] data_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    phy_mgmt_resp #(.DATA_W(DW), .PHY_ADDR(4'd0)) u_dut (
        .clk(clk), .rst(rst), .link_up_i(link_up_i),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk_cmd(input logic [3:0] a, input logic [3:0] r, input logic wr);
        logic [DW-1:0] c;
        c = '0;
        c[15:12] = a;
        c[7:4] = r;
        c[1] = wr;
        return c;
    endfunction

    task automatic issue(input logic [DW-1:0] c);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = c;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic set_data(input logic [DW-1:0] v);
        @(negedge clk);
        data_we = 1'b1; data_wdata = v;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic phy_wr(input logic [3:0] r, input logic [15:0] v);
        set_data({16'h0, v});
        issue(mk_cmd(4'd0, r, 1'b1));
    endtask

    task automatic phy_rd(input logic [3:0] r, output logic [DW-1:0] v);
        issue(mk_cmd(4'd0, r, 1'b0));
        v = data_rdata;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check("R1 cmd", cmd_rdata, '0);
        check("R1 data", data_rdata, '0);
        phy_rd(4'd0, v); check("R1 ctrl", v, 32'h3100);
        phy_rd(4'd4, v); check("R1 adv", v, 32'h0);
        phy_rd(4'd1, v); check("R1 status", v, 32'hFE28);
    endtask

    task automatic t_cmd_store();
        issue(32'hA5A5_F0F3);
        check("R2 busy cleared", cmd_rdata, 32'hA5A5_F0F2);
    endtask

    task automatic t_foreign();
        logic [DW-1:0] v;
        phy_wr(4'd4, 16'h1111);
        set_data(32'h0000_BEEF);
        issue(mk_cmd(4'd3, 4'd2, 1'b0));
        check("R3 read ignored", data_rdata, 32'h0000_BEEF);
        issue(mk_cmd(4'd3, 4'd4, 1'b1));
        phy_rd(4'd4, v); check("R3 write ignored", v, 32'h1111);
    endtask

    task automatic t_link();
        logic [DW-1:0] v;
        @(negedge clk); link_up_i = 1'b1;
        @(negedge clk);
        phy_rd(4'd1, v); check("R11 link up", v, 32'hFE2C);
        check("R4 status", v, 32'hFE2C);
        @(negedge clk); link_up_i = 1'b0;
        @(negedge clk);
        phy_rd(4'd1, v); check("R11 link down", v, 32'hFE28);
        @(negedge clk); link_up_i = 1'b1;
    endtask

    task automatic t_ctrl();
        logic [DW-1:0] v;
        phy_wr(4'd0, 16'h7FFF);
        phy_rd(4'd0, v); check("R5 mask 15 and 9", v, 32'h7DFF);
        phy_wr(4'd0, 16'h0240);
        phy_rd(4'd0, v); check("R5 bit9 cleared", v, 32'h0040);
        phy_wr(4'd4, 16'h5A5A);
        phy_wr(4'd0, 16'hFFFF);
        phy_rd(4'd0, v); check("R6 reload", v, 32'h3100);
        phy_rd(4'd4, v); check("R6 adv kept", v, 32'h5A5A);
        phy_rd(4'd1, v); check("R6 link kept", v, 32'hFE2C);
    endtask

    task automatic t_fixed();
        logic [DW-1:0] v;
        phy_wr(4'd2, 16'hFFFF);
        phy_rd(4'd2, v); check("R7 id hi", v, 32'h0044);
        phy_wr(4'd3, 16'h0000);
        phy_rd(4'd3, v); check("R7 id lo", v, 32'h1400);
        phy_rd(4'd5, v); check("R9 partner", v, 32'h0DE0);
    endtask

    task automatic t_adv();
        logic [DW-1:0] v;
        set_data(32'hDEAD_C3A5);
        issue(mk_cmd(4'd0, 4'd4, 1'b1));
        phy_rd(4'd4, v); check("R8 adv low half", v, 32'hC3A5);
        phy_wr(4'd4, 16'h0000);
        phy_rd(4'd4, v); check("R8 adv zero", v, 32'h0);
    endtask

    task automatic t_unknown();
        logic [DW-1:0] v;
        phy_wr(4'd4, 16'h1234);
        phy_wr(4'd0, 16'h0100);
        phy_wr(4'd9, 16'hFFFF);
        phy_wr(4'd15, 16'hFFFF);
        phy_rd(4'd9, v); check("R10 unknown 9 reads zero", v, 32'h0);
        phy_rd(4'd6, v); check("R10 unknown 6 reads zero", v, 32'h0);
        phy_rd(4'd4, v); check("R10 adv untouched", v, 32'h1234);
        phy_rd(4'd0, v); check("R10 ctrl untouched", v, 32'h0100);
    endtask

    task automatic t_collide();
        logic [DW-1:0] v;
        set_data(32'h0000_00AA);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = mk_cmd(4'd0, 4'd4, 1'b1);
        data_we = 1'b1; data_wdata = 32'h0000_0055;
        @(negedge clk);
        cmd_we = 1'b0; data_we = 1'b0;
        check("R12 data written", data_rdata, 32'h55);
        phy_rd(4'd4, v); check("R12 write used old data", v, 32'hAA);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = mk_cmd(4'd0, 4'd3, 1'b0);
        data_we = 1'b1; data_wdata = 32'h0000_7777;
        @(negedge clk);
        cmd_we = 1'b0; data_we = 1'b0;
        check("R12 read wins", data_rdata, 32'h1400);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cmd_store();
        t_foreign();
        t_link();
        t_ctrl();
        t_fixed();
        t_adv();
        t_unknown();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule